// File: doc/BRIEF.md
# Privileged Interrupt Pending Selector

This block decides which local interrupt a hart should take next. It receives the pending and enable vectors, a per-line delegation mask, the current privilege level and the machine and supervisor global enable bits. From these it reports whether any interrupt may be taken now and, if so, the number of the line to take.

An interrupt line is a candidate when it is both pending and enabled. Each candidate is then gated by the global enable of the mode it targets. A line with its delegation bit clear targets machine mode. A line with its delegation bit set targets supervisor mode. Among the lines that pass their gate, the lowest-numbered one wins. The result is registered on the rising clock edge by default, so trap-entry logic sees a stable choice one cycle after the inputs settle. A parameter selects a purely combinational output instead. A second parameter selects how the lowest set bit is found: a priority scan or an isolate-and-encode network.

Top module: `irq_pick_sel`

## Requirements
- R1: A line whose enable bit is 0 is never selected, even when its pending bit is 1.
- R2: A line with delegation bit 0 may be taken only when the privilege is user (0) or supervisor (1), or when the privilege is machine (3) and `m_gie_i` is 1.
- R3: A line with delegation bit 1 may be taken only when the privilege is user (0), or when the privilege is supervisor (1) and `s_gie_i` is 1. At machine privilege it is never taken.
- R4: When several lines pass their gates, `cause_o` holds the lowest bit index among them.
- R5: When no line passes its gate, `take_o` is 0.
- R6: `take_o` and `cause_o` reflect the inputs as sampled at the previous rising clock edge, which is a latency of one cycle.
- R7: While `rst` is 1 at a rising edge, `take_o` and `cause_o` become 0 after that edge.
- R8: Whenever `take_o` is 0, `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | 16 | Interrupt pending vector |
| en_i | input | 16 | Interrupt enable vector |
| deleg_i | input | 16 | Delegation mask: 1 sends the line to supervisor mode |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt may be taken |
| cause_o | output | 4 | Index of the selected interrupt line |

## Verification
The bound checker tests several rules on every cycle. The reported line must have been pending and enabled. The machine gate must block everything when the hart runs at machine level with its enable clear. No delegated line may win at machine level. An empty candidate set must give no result. The index must stay at zero while nothing is taken, and reset must clear the outputs. Two things can only be shown by the bench's scenarios, which compare the outputs with an independent model of the rule across privilege levels, enable settings and delegation masks. The first is that the lowest surviving line is chosen. The second is that the supervisor gate opens and closes exactly as stated, for example that a delegated line is taken at user level with the supervisor enable clear.

// File: rtl/irq_pick_pkg.sv
`timescale 1ns/1ps
package irq_pick_pkg;
   typedef enum logic [1:0] {
      LVL_USER  = 2'd0,
      LVL_SUPER = 2'd1,
      LVL_RSVD  = 2'd2,
      LVL_MACH  = 2'd3
   } lvl_e;

   localparam int ENC_SCAN = 0;
   localparam int ENC_ISO  = 1;
endpackage

// File: rtl/irq_pick_gate.sv
`timescale 1ns/1ps
module irq_pick_gate
   import irq_pick_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] pend,
   input  logic [W-1:0] en,
   input  logic [W-1:0] deleg,
   input  logic [1:0]   priv,
   input  logic         m_gie,
   input  logic         s_gie,
   output logic [W-1:0] qual
);
   logic         below_m;
   logic         below_s;
   logic         m_open;
   logic         s_open;
   logic [W-1:0] cand;
   logic [W-1:0] m_lane;
   logic [W-1:0] s_lane;

   always_comb begin
      below_m = (priv != LVL_MACH);
      below_s = (priv == LVL_USER);
      m_open  = below_m | ((priv == LVL_MACH) & m_gie);
      s_open  = below_s | ((priv == LVL_SUPER) & s_gie);
   end

   assign cand   = pend & en;
   assign m_lane = cand & ~deleg & {W{m_open}};
   assign s_lane = cand &  deleg & {W{s_open}};
   assign qual   = m_lane | s_lane;
endmodule

// File: rtl/irq_pick_lsb.sv
`timescale 1ns/1ps
module irq_pick_lsb
   import irq_pick_pkg::*;
#(
   parameter int W     = 16,
   parameter int STYLE = ENC_SCAN,
   localparam int IW   = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   assign found = |vec;

   generate
      if (STYLE == ENC_SCAN) begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (vec[i]) idx = IW'(i);
            end
         end
      end else begin : g_iso
         logic [W-1:0] iso;
         assign iso = vec & (~vec + W'(1));

         function automatic logic [W-1:0] bit_mask(input int b);
            logic [W-1:0] m;
            for (int i = 0; i < W; i++) m[i] = ((i >> b) & 1) == 1;
            return m;
         endfunction

         for (genvar b = 0; b < IW; b++) begin : g_bit
            localparam logic [W-1:0] MSK = bit_mask(b);
            assign idx[b] = |(iso & MSK);
         end
      end
   endgenerate
endmodule

// File: rtl/irq_pick_sel.sv
`timescale 1ns/1ps
module irq_pick_sel
   import irq_pick_pkg::*;
#(
   parameter int W         = 16,
   parameter int ENC_STYLE = ENC_SCAN,
   parameter bit REG_OUT   = 1'b1,
   localparam int IW       = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  pend_i,
   input  logic [W-1:0]  en_i,
   input  logic [W-1:0]  deleg_i,
   input  logic [1:0]    priv_i,
   input  logic          m_gie_i,
   input  logic          s_gie_i,
   output logic          take_o,
   output logic [IW-1:0] cause_o
);
   generate
      if (W < 2 || W > 64) begin : g_bad_w
         $error("irq_pick_sel: W must lie in 2..64");
      end
      if (ENC_STYLE != ENC_SCAN && ENC_STYLE != ENC_ISO) begin : g_bad_enc
         $error("irq_pick_sel: unknown ENC_STYLE");
      end
   endgenerate

   logic [W-1:0]  qual;
   logic          hit;
   logic [IW-1:0] hit_idx;

   irq_pick_gate #(.W(W)) u_gate (
      .pend  (pend_i),
      .en    (en_i),
      .deleg (deleg_i),
      .priv  (priv_i),
      .m_gie (m_gie_i),
      .s_gie (s_gie_i),
      .qual  (qual)
   );

   irq_pick_lsb #(.W(W), .STYLE(ENC_STYLE)) u_lsb (
      .vec   (qual),
      .found (hit),
      .idx   (hit_idx)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               take_o  <= 1'b0;
               cause_o <= '0;
            end else begin
               take_o  <= hit;
               cause_o <= hit ? hit_idx : '0;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst;
         assign take_o  = hit;
         assign cause_o = hit ? hit_idx : '0;
      end
   endgenerate
endmodule

// File: rtl/irq_pick_chk.sv
`timescale 1ns/1ps
module irq_pick_chk
   import irq_pick_pkg::*;
#(
   parameter int W       = 16,
   parameter bit REG_OUT = 1'b1,
   localparam int IW     = $clog2(W)
) (
   input logic          clk,
   input logic          rst,
   input logic [W-1:0]  pend_i,
   input logic [W-1:0]  en_i,
   input logic [W-1:0]  deleg_i,
   input logic [1:0]    priv_i,
   input logic          m_gie_i,
   input logic          take_o,
   input logic [IW-1:0] cause_o
);
   generate
      if (REG_OUT) begin : g_seq
         // R1: the chosen line was pending and enabled one cycle earlier
         assert_cand_only_R1: assert property (@(posedge clk) disable iff (rst)
            take_o |-> ((($past(pend_i & en_i)) >> cause_o) & W'(1)) != '0);

         // R2: machine level with its enable clear lets nothing through
         assert_m_closed_R2: assert property (@(posedge clk) disable iff (rst)
            (priv_i == LVL_MACH && !m_gie_i) |=> !take_o);

         // R3: a delegated line never wins at machine level
         assert_no_deleg_at_m_R3: assert property (@(posedge clk) disable iff (rst)
            (take_o && $past(priv_i) == LVL_MACH)
               |-> ((($past(deleg_i)) >> cause_o) & W'(1)) == '0);

         // R5: an empty candidate set yields no result
         assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
            ((pend_i & en_i) == '0) |=> !take_o);

         // R7: reset clears the outputs
         assert_reset_R7: assert property (@(posedge clk)
            rst |=> (!take_o && cause_o == '0));
      end
   endgenerate

   // R8: the index rests at zero when nothing is taken
   assert_idx_rest_R8: assert property (@(posedge clk) disable iff (rst)
      !take_o |-> cause_o == '0);
endmodule

bind irq_pick_sel irq_pick_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .pend_i  (pend_i),
   .en_i    (en_i),
   .deleg_i (deleg_i),
   .priv_i  (priv_i),
   .m_gie_i (m_gie_i),
   .take_o  (take_o),
   .cause_o (cause_o)
);

// File: tb/sim_irq_pick_sel.sv
`timescale 1ns/1ps
module sim_irq_pick_sel;
   typedef struct {
      logic       v;
      logic [3:0] idx;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] pend = '0, en = '0, deleg = '0;
   logic [1:0]  priv = 2'd3;
   logic        mie = 1'b0, sie = 1'b0;
   logic        take;
   logic [3:0]  cause;

   int   n_run  = 0;
   int   n_fail = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   irq_pick_sel u0 (
      .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .deleg_i(deleg),
      .priv_i(priv), .m_gie_i(mie), .s_gie_i(sie),
      .take_o(take), .cause_o(cause)
   );

   function automatic exp_t model(input logic [15:0] p, input logic [15:0] e,
                                  input logic [15:0] d, input logic [1:0] lv,
                                  input logic m, input logic s, input string tag);
      exp_t r;
      logic m_ok, s_ok;
      m_ok = (lv == 2'd0) || (lv == 2'd1) || (lv == 2'd3 && m);
      s_ok = (lv == 2'd0) || (lv == 2'd1 && s);
      r.v = 1'b0; r.idx = 4'd0; r.tag = tag;
      for (int i = 0; i < 16; i++) begin
         if (!r.v && p[i] && e[i] && (d[i] ? s_ok : m_ok)) begin
            r.v = 1'b1; r.idx = 4'(i);
         end
      end
      return r;
   endfunction

   task automatic drive(input logic [15:0] p, input logic [15:0] e,
                        input logic [15:0] d, input logic [1:0] lv,
                        input logic m, input logic s, input string tag);
      @(negedge clk);
      pend = p; en = e; deleg = d; priv = lv; mie = m; sie = s;
      sb.push_back(model(p, e, d, lv, m, s, tag));
   endtask

   // monitor: one cycle after each push the registered result is compared
   always @(posedge clk) begin
      #2;
      if (!rst && sb.size() > 0) begin
         exp_t x;
         x = sb.pop_front();
         n_run++;
         if (take !== x.v || cause !== x.idx) begin
            n_fail++;
            $display("FAIL %s: got take=%b cause=%0d, expected take=%b cause=%0d",
                     x.tag, take, cause, x.v, x.idx);
         end
      end
   end

   task automatic check_reset(input string tag);
      @(posedge clk); #2;
      n_run++;
      if (take !== 1'b0 || cause !== 4'd0) begin
         n_fail++;
         $display("FAIL %s: got take=%b cause=%0d, expected take=0 cause=0",
                  tag, take, cause);
      end
   endtask

   initial begin
      #(8 * 50000);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      pend = 16'hFFFF; en = 16'hFFFF; mie = 1'b1;
      check_reset("R7 reset state");
      @(negedge clk); rst = 1'b0;

      drive(16'h0010, 16'h0000, 16'h0000, 2'd0, 1, 1, "R1 pending not enabled");
      drive(16'h0030, 16'h0020, 16'h0000, 2'd3, 1, 0, "R1 only enabled bit 5");
      drive(16'h0008, 16'hFFFF, 16'h0000, 2'd3, 0, 1, "R2 machine closed");
      drive(16'h0008, 16'hFFFF, 16'h0000, 2'd3, 1, 0, "R2 machine open");
      drive(16'h0008, 16'hFFFF, 16'h0000, 2'd1, 0, 0, "R2 below machine");
      drive(16'h0008, 16'hFFFF, 16'h0000, 2'd0, 0, 0, "R2 user level");
      drive(16'h0200, 16'hFFFF, 16'h0200, 2'd3, 1, 1, "R3 delegated at machine");
      drive(16'h0200, 16'hFFFF, 16'h0200, 2'd1, 1, 0, "R3 super closed");
      drive(16'h0200, 16'hFFFF, 16'h0200, 2'd1, 0, 1, "R3 super open");
      drive(16'h0200, 16'hFFFF, 16'h0200, 2'd0, 0, 0, "R3 user level");
      drive(16'h8421, 16'hFFFF, 16'h0000, 2'd0, 0, 0, "R4 lowest of many");
      drive(16'h8421, 16'hFFFF, 16'h0001, 2'd3, 1, 1, "R4 low delegated skipped");
      drive(16'h8421, 16'h8400, 16'h0000, 2'd3, 1, 1, "R4 lowest enabled");
      drive(16'h8000, 16'hFFFF, 16'h0000, 2'd1, 0, 0, "R4 top line");
      drive(16'h0000, 16'hFFFF, 16'hFFFF, 2'd0, 1, 1, "R5 nothing pending");
      drive(16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd3, 1, 1, "R5 all gated off");
      drive(16'h0040, 16'hFFFF, 16'h0000, 2'd0, 0, 0, "R6 first value");
      drive(16'h0004, 16'hFFFF, 16'h0000, 2'd0, 0, 0, "R6 next value");
      drive(16'h0000, 16'h0000, 16'h0000, 2'd3, 0, 0, "R8 index at rest");

      for (int k = 0; k < 400; k++) begin
         logic [1:0] lv;
         lv = 2'($urandom_range(0, 2));
         if (lv == 2'd2) lv = 2'd3;
         drive(16'($urandom), 16'($urandom), 16'($urandom), lv,
               1'($urandom), 1'($urandom), "R4 random sweep");
      end

      @(negedge clk);
      pend = 16'hFFFF; en = 16'hFFFF; deleg = '0; priv = 2'd0;
      rst = 1'b1;
      check_reset("R7 reset mid-run");
      @(negedge clk); rst = 1'b0;
      drive(16'h0100, 16'hFFFF, 16'h0000, 2'd0, 0, 0, "R6 after reset");

      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule